// File: doc/BRIEF.md
# SDRAM Refresh Scheduler with Postponement

This block sits beside the main command arbiter of a DDR SDRAM controller and owns the refresh side of the command bus. A programmable interval timer ticks once per refresh interval, and each tick adds one owed refresh to a saturating counter. While refreshes are owed, the block raises a request. When the arbiter grants the bus, the block precharges every bank and then issues the owed auto-refresh commands back to back. If the owed count reaches the programmed postponement limit, the block takes the bus without waiting for a grant.

A standby request takes the same route up to the precharge. The block then drops the clock enable together with a refresh command, which places the device in self-refresh. It holds there until the request is withdrawn. On exit it raises the clock enable, waits a programmable recovery time and clears the owed count, because the device refreshed itself while in standby. Between sequences the command pins carry NOP with the clock enable high.

Top module: `sdram_refresh_sched`

## Requirements
- R1: After reset and whenever busy_o is low, cke_o=1 and the pins carry NOP (cs_no=0, ras_no=1, cas_no=1, we_no=1, a10_o=0), with busy_o, urgent_o, sr_ack_o and ref_req_o all low after reset.
- R2: With interval_i=N>0, one refresh becomes owed every N cycles, and ref_req_o is high in idle while any refresh is owed. With interval_i=0 nothing accrues and ref_req_o stays low.
- R3: The owed count saturates at post_limit_i: ticks beyond the limit are dropped, so a postponed burst never holds more refreshes than the limit. urgent_o is high while the count equals the limit.
- R4: A refresh sequence starts only on grant_i, or when urgent_o is set. Its first command is precharge-all (cs_no=0, ras_no=0, cas_no=1, we_no=0, a10_o=1), issued in the first cycle busy_o is high.
- R5: The first auto-refresh (cs_no=0, ras_no=0, cas_no=0, we_no=1, cke_o high in this and the previous cycle) follows precharge-all after max(trp_i,1) cycles. Consecutive auto-refreshes are max(trfc_i,1) cycles apart, and busy_o falls max(trfc_i,1) cycles after the last one.
- R6: One granted sequence issues as many auto-refresh commands as are owed, and each one reduces the owed count by one.
- R7: When urgent_o is high in idle, busy_o rises in the next cycle with no grant.
- R8: With sr_req_i and grant_i both high in idle, the block issues precharge-all, and max(trp_i,1) cycles later issues self-refresh entry: the auto-refresh pattern with cke_o falling in that cycle. From the next cycle sr_ack_o=1 and cke_o=0 until sr_req_i drops. Without a grant, a standby request does not start a sequence.
- R9: In the cycle after sr_req_i is seen low in self-refresh, cke_o=1 and sr_ack_o=0. busy_o falls max(txsr_i,1) cycles after that cycle, and the owed count is zero by then.
- R10: If a standby request and owed refreshes are both pending when a grant arrives, self-refresh entry wins and no auto-refresh is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| interval_i | input | IW | Cycles per refresh tick, 0 disables ticks |
| post_limit_i | input | OW | Maximum number of owed refreshes |
| trp_i | input | TW | Precharge-to-refresh gap in cycles |
| trfc_i | input | TW | Refresh-to-refresh gap in cycles |
| txsr_i | input | TW | Self-refresh exit recovery in cycles |
| grant_i | input | 1 | Arbiter hands the command bus to this block |
| ref_req_o | output | 1 | Refresh or standby pending, bus wanted |
| urgent_o | output | 1 | Postponement limit reached, bus taken |
| busy_o | output | 1 | Block is driving the command bus |
| sr_req_i | input | 1 | Standby request |
| sr_ack_o | output | 1 | Device is in self-refresh |
| cke_o | output | 1 | Clock enable |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| a10_o | output | 1 | Address bit 10, all-banks select |

## Verification
The assertions check on every cycle the rules that need no counting: idle means NOP with the clock enable high, every sequence opens with precharge-all, auto-refresh appears only while the bus is held, a falling clock enable always carries the refresh pattern, acknowledge implies the clock enable is low, and an urgent state in idle takes the bus in the next cycle. The bench scenarios show the quantitative behaviour. They cover tick accrual and saturation, the number of refreshes in one burst, the cycle gaps set by trp_i, trfc_i and txsr_i, and the precedence of standby over owed refreshes. They also show that self-refresh exit clears the owed count.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PREA,
    CMD_REF
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREA,
    ST_RP,
    ST_REF,
    ST_RFC,
    ST_SRE,
    ST_SR,
    ST_XS
  } st_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } pins_t;

  function automatic pins_t enc_cmd(cmd_e c);
    pins_t p;
    case (c)
      CMD_PREA: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
      CMD_REF:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
      default:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ref_tick_gen.sv
module ref_tick_gen #(
  parameter int IW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] interval_i,
  output logic          tick_o
);
  localparam logic [IW-1:0] ONE = IW'(1);

  logic [IW-1:0] cnt_q;
  logic          wrap;

  // >= keeps the wrap sane if the interval shrinks mid-count
  assign wrap   = (interval_i != '0) && (cnt_q >= interval_i - ONE);
  assign tick_o = wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (interval_i == '0)   cnt_q <= '0;
    else if (wrap)               cnt_q <= '0;
    else                         cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/ref_owed_ctr.sv
module ref_owed_ctr #(
  parameter int OW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          dec_i,
  input  logic          clr_i,
  input  logic [OW-1:0] limit_i,
  output logic [OW-1:0] owed_o,
  output logic          full_o
);
  localparam logic [OW-1:0] ONE = OW'(1);

  logic [OW-1:0] owed_q, owed_d;

  always_comb begin
    owed_d = owed_q;
    if (dec_i && owed_q != '0) owed_d = owed_q - ONE;
    if (tick_i && owed_d < limit_i) owed_d = owed_d + ONE;
    if (clr_i) owed_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owed_q <= '0;
    else         owed_q <= owed_d;
  end

  assign owed_o = owed_q;
  assign full_o = (limit_i != '0) && (owed_q >= limit_i);
endmodule

// File: rtl/ref_seq_fsm.sv
module ref_seq_fsm
  import ref_sched_pkg::*;
#(
  parameter int OW = 4,
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [OW-1:0] owed_i,
  input  logic          full_i,
  input  logic          grant_i,
  input  logic          sr_req_i,
  input  logic [TW-1:0] trp_i,
  input  logic [TW-1:0] trfc_i,
  input  logic [TW-1:0] txsr_i,
  output cmd_e          cmd_o,
  output logic          cke_o,
  output logic          busy_o,
  output logic          sr_ack_o,
  output logic          req_o,
  output logic          dec_o,
  output logic          clr_o
);
  localparam logic [TW-1:0] T_ONE = TW'(1);
  localparam logic [OW-1:0] O_ONE = OW'(1);

  st_e           st_q, st_d;
  logic [TW-1:0] wait_q, wait_d;
  logic          srp_q, srp_d;   // current sequence heads for self-refresh
  logic          owed_nz, owed_gt1;
  st_e           after_rp;

  assign owed_nz  = owed_i != '0;
  assign owed_gt1 = owed_i > O_ONE;
  assign after_rp = srp_q ? ST_SRE : ST_REF;

  always_comb begin
    st_d   = st_q;
    wait_d = wait_q;
    srp_d  = srp_q;
    unique case (st_q)
      ST_IDLE: begin
        if (sr_req_i && grant_i) begin
          st_d  = ST_PREA;
          srp_d = 1'b1;
        end else if (owed_nz && (grant_i || full_i)) begin
          st_d  = ST_PREA;
          srp_d = 1'b0;
        end
      end
      ST_PREA: begin
        if (trp_i <= T_ONE) st_d = after_rp;
        else begin
          st_d   = ST_RP;
          wait_d = trp_i - T_ONE;
        end
      end
      ST_RP: begin
        if (wait_q <= T_ONE) st_d = after_rp;
        else                 wait_d = wait_q - T_ONE;
      end
      ST_REF: begin
        if (trfc_i <= T_ONE) st_d = owed_gt1 ? ST_REF : ST_IDLE;
        else begin
          st_d   = ST_RFC;
          wait_d = trfc_i - T_ONE;
        end
      end
      ST_RFC: begin
        if (wait_q <= T_ONE) st_d = owed_nz ? ST_REF : ST_IDLE;
        else                 wait_d = wait_q - T_ONE;
      end
      ST_SRE: st_d = ST_SR;
      ST_SR: begin
        if (!sr_req_i) begin
          st_d   = ST_XS;
          wait_d = txsr_i;
        end
      end
      ST_XS: begin
        if (wait_q <= T_ONE) st_d = ST_IDLE;
        else                 wait_d = wait_q - T_ONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      wait_q <= '0;
      srp_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      wait_q <= wait_d;
      srp_q  <= srp_d;
    end
  end

  always_comb begin
    cmd_o = CMD_NOP;
    if (st_q == ST_PREA) cmd_o = CMD_PREA;
    if (st_q == ST_REF || st_q == ST_SRE) cmd_o = CMD_REF;
  end

  assign cke_o    = !(st_q == ST_SRE || st_q == ST_SR);
  assign busy_o   = st_q != ST_IDLE;
  assign sr_ack_o = st_q == ST_SR;
  assign req_o    = (st_q == ST_IDLE) && (owed_nz || sr_req_i);
  assign dec_o    = st_q == ST_REF;
  assign clr_o    = st_q == ST_SRE || st_q == ST_SR || st_q == ST_XS;
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import ref_sched_pkg::*;
#(
  parameter int IW = 16,
  parameter int OW = 4,
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] interval_i,
  input  logic [OW-1:0] post_limit_i,
  input  logic [TW-1:0] trp_i,
  input  logic [TW-1:0] trfc_i,
  input  logic [TW-1:0] txsr_i,
  input  logic          grant_i,
  output logic          ref_req_o,
  output logic          urgent_o,
  output logic          busy_o,
  input  logic          sr_req_i,
  output logic          sr_ack_o,
  output logic          cke_o,
  output logic          cs_no,
  output logic          ras_no,
  output logic          cas_no,
  output logic          we_no,
  output logic          a10_o
);
  logic          tick, dec, clr, full;
  logic [OW-1:0] owed;
  cmd_e          cmd;
  pins_t         pins;

  ref_tick_gen #(.IW(IW)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .interval_i (interval_i),
    .tick_o     (tick)
  );

  ref_owed_ctr #(.OW(OW)) u_owed (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .dec_i   (dec),
    .clr_i   (clr),
    .limit_i (post_limit_i),
    .owed_o  (owed),
    .full_o  (full)
  );

  ref_seq_fsm #(.OW(OW), .TW(TW)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .owed_i   (owed),
    .full_i   (full),
    .grant_i  (grant_i),
    .sr_req_i (sr_req_i),
    .trp_i    (trp_i),
    .trfc_i   (trfc_i),
    .txsr_i   (txsr_i),
    .cmd_o    (cmd),
    .cke_o    (cke_o),
    .busy_o   (busy_o),
    .sr_ack_o (sr_ack_o),
    .req_o    (ref_req_o),
    .dec_o    (dec),
    .clr_o    (clr)
  );

  assign pins     = enc_cmd(cmd);
  assign cs_no    = pins.cs_n;
  assign ras_no   = pins.ras_n;
  assign cas_no   = pins.cas_n;
  assign we_no    = pins.we_n;
  assign a10_o    = pins.a10;
  assign urgent_o = full;
endmodule

// File: rtl/ref_sched_chk.sv
module ref_sched_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cke_o,
  input logic cs_no,
  input logic ras_no,
  input logic cas_no,
  input logic we_no,
  input logic a10_o,
  input logic busy_o,
  input logic urgent_o,
  input logic sr_ack_o
);
  logic is_nop, is_prea, is_ref;
  assign is_nop  = !cs_no && ras_no && cas_no && we_no;
  assign is_prea = !cs_no && !ras_no && cas_no && !we_no && a10_o;
  assign is_ref  = !cs_no && !ras_no && !cas_no && we_no;

  a_r1_idle_is_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cke_o && is_nop));

  a_r4_seq_opens_with_prea: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> is_prea);

  a_r6_ref_only_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ref && cke_o) |-> busy_o);

  a_r7_urgent_takes_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (urgent_o && !busy_o) |=> busy_o);

  a_r8_cke_fall_is_sre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> is_ref);

  a_r8_ack_needs_cke_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_ack_o |-> !cke_o);

  a_r9_cke_rise_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> ($past(sr_ack_o) && busy_o && !sr_ack_o));
endmodule

bind sdram_refresh_sched ref_sched_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cke_o    (cke_o),
  .cs_no    (cs_no),
  .ras_no   (ras_no),
  .cas_no   (cas_no),
  .we_no    (we_no),
  .a10_o    (a10_o),
  .busy_o   (busy_o),
  .urgent_o (urgent_o),
  .sr_ack_o (sr_ack_o)
);

// File: tb/tb_sdram_refresh_sched.sv
module tb_sdram_refresh_sched;
  localparam int CLK_P = 10;
  localparam int IW = 16;
  localparam int OW = 4;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [IW-1:0] interval_i = '0;
  logic [OW-1:0] post_limit_i = OW'(8);
  logic [TW-1:0] trp_i = TW'(2), trfc_i = TW'(3), txsr_i = TW'(4);
  logic          grant_i = 1'b0, sr_req_i = 1'b0;
  logic          ref_req_o, urgent_o, busy_o, sr_ack_o;
  logic          cke_o, cs_no, ras_no, cas_no, we_no, a10_o;

  always #(CLK_P/2) clk = ~clk;

  sdram_refresh_sched #(.IW(IW), .OW(OW), .TW(TW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .interval_i(interval_i), .post_limit_i(post_limit_i),
    .trp_i(trp_i), .trfc_i(trfc_i), .txsr_i(txsr_i), .grant_i(grant_i),
    .ref_req_o(ref_req_o), .urgent_o(urgent_o), .busy_o(busy_o),
    .sr_req_i(sr_req_i), .sr_ack_o(sr_ack_o), .cke_o(cke_o), .cs_no(cs_no),
    .ras_no(ras_no), .cas_no(cas_no), .we_no(we_no), .a10_o(a10_o)
  );

  int vecs = 0, bad = 0;
  int ncyc = 0;
  int pre_at, sre_at, srx_at, fall_at, ref_n, pre_n, sre_n;
  int ref_at [8];
  logic cke_q = 1'b1, busy_q = 1'b0;

  // command monitor, sampled at the falling edge
  always @(negedge clk) begin
    ncyc++;
    if (cke_o && cke_q && !cs_no && !ras_no && !cas_no && we_no) begin
      if (ref_n < 8) ref_at[ref_n] = ncyc;
      ref_n++;
    end
    if (!cs_no && !ras_no && cas_no && !we_no && a10_o) begin
      pre_at = ncyc;
      pre_n++;
    end
    if (!cke_o && cke_q && !cs_no && !ras_no && !cas_no && we_no) begin
      sre_at = ncyc;
      sre_n++;
    end
    if (cke_o && !cke_q) srx_at = ncyc;
    if (busy_q && !busy_o) fall_at = ncyc;
    cke_q  = cke_o;
    busy_q = busy_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clr_mon();
    ref_n = 0; pre_n = 0; sre_n = 0;
    pre_at = -1; sre_at = -1; srx_at = -1; fall_at = -1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy_o; i++) step(1);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    step(3);
    rst_ni = 1'b1;
    step(1);
    clr_mon();
    chk(cke_o == 1'b1, "R1 cke after reset", int'(cke_o), 1);
    chk(!cs_no && ras_no && cas_no && we_no && !a10_o, "R1 NOP after reset",
        int'({cs_no, ras_no, cas_no, we_no, a10_o}), 5'b01110);
    chk({busy_o, urgent_o, sr_ack_o, ref_req_o} == 4'b0, "R1 status low",
        int'({busy_o, urgent_o, sr_ack_o, ref_req_o}), 0);
    step(100);
    chk(ref_req_o == 1'b0 && pre_n == 0, "R2 interval 0 accrues nothing",
        int'(ref_req_o) + pre_n, 0);
  endtask

  task automatic t_burst();
    trp_i = 2; trfc_i = 3; post_limit_i = 8;
    interval_i = 40;
    for (int i = 0; i < 200 && !ref_req_o; i++) step(1);
    chk(ref_req_o == 1'b1, "R2 request after first tick", int'(ref_req_o), 1);
    clr_mon();
    step(2 * 40 + 5);
    chk(busy_o == 1'b0 && pre_n == 0, "R4 no start without grant", pre_n, 0);
    chk(urgent_o == 1'b0, "R3 below limit not urgent", int'(urgent_o), 0);
    grant_i = 1'b1;
    step(1);
    grant_i = 1'b0;
    chk(busy_o && pre_n == 1 && pre_at == ncyc, "R4 precharge-all opens sequence", pre_n, 1);
    wait_idle();
    chk(ref_n == 3, "R6 burst drains three owed", ref_n, 3);
    chk(ref_at[0] - pre_at == 2, "R5 trp gap", ref_at[0] - pre_at, 2);
    chk(ref_at[1] - ref_at[0] == 3, "R5 trfc gap 1", ref_at[1] - ref_at[0], 3);
    chk(ref_at[2] - ref_at[1] == 3, "R5 trfc gap 2", ref_at[2] - ref_at[1], 3);
    chk(fall_at - ref_at[2] == 3, "R5 release after last refresh", fall_at - ref_at[2], 3);
    interval_i = 0;
    step(1);
    chk(ref_req_o == 1'b0, "R6 owed empty after burst", int'(ref_req_o), 0);
  endtask

  task automatic t_urgent();
    int uc;
    post_limit_i = 4; trp_i = 0; trfc_i = 1;
    clr_mon();
    interval_i = 10;
    for (int i = 0; i < 100 && !urgent_o; i++) step(1);
    uc = ncyc;
    chk(urgent_o && !busy_o, "R3 urgent at limit", int'(urgent_o), 1);
    step(1);
    chk(busy_o == 1'b1 && pre_at == uc + 1, "R7 urgent takes bus next cycle", pre_at - uc, 1);
    wait_idle();
    interval_i = 0;
    chk(ref_n == 4, "R6 burst equals limit", ref_n, 4);
    chk(ref_at[0] - pre_at == 1, "R5 trp 0 acts as 1", ref_at[0] - pre_at, 1);
    chk(ref_at[3] - ref_at[0] == 3, "R5 back-to-back refresh", ref_at[3] - ref_at[0], 3);
    chk(fall_at - ref_at[3] == 1, "R5 release with trfc 1", fall_at - ref_at[3], 1);
  endtask

  task automatic t_saturate();
    post_limit_i = 2; trp_i = 20; trfc_i = 1;
    step(2);
    clr_mon();
    interval_i = 3;
    for (int i = 0; i < 50 && !busy_o; i++) step(1);
    step(10);
    interval_i = 0;
    wait_idle();
    chk(ref_n == 2, "R3 saturated count bounds burst", ref_n, 2);
  endtask

  task automatic t_selfref();
    post_limit_i = 8; trp_i = 3; txsr_i = 4;
    interval_i = 7;
    for (int i = 0; i < 50 && !ref_req_o; i++) step(1);
    interval_i = 0;
    clr_mon();
    sr_req_i = 1'b1;
    step(5);
    chk(busy_o == 1'b0 && ref_req_o == 1'b1, "R8 no standby start without grant",
        int'(busy_o), 0);
    grant_i = 1'b1;
    step(1);
    grant_i = 1'b0;
    chk(busy_o && pre_at == ncyc, "R8 precharge-all before self-refresh", pre_n, 1);
    for (int i = 0; i < 20 && !sr_ack_o; i++) step(1);
    chk(sre_n == 1 && sre_at - pre_at == 3, "R8 entry after trp", sre_at - pre_at, 3);
    chk(ncyc == sre_at + 1 && !cke_o, "R8 ack the cycle after entry", ncyc - sre_at, 1);
    chk(ref_n == 0, "R10 standby wins over owed refresh", ref_n, 0);
    step(10);
    chk(sr_ack_o && !cke_o && ref_n == 0, "R8 held in self-refresh", int'(cke_o), 0);
    sr_req_i = 1'b0;
    step(1);
    chk(cke_o && !sr_ack_o && busy_o && srx_at == ncyc, "R9 exit raises cke",
        int'({cke_o, sr_ack_o, busy_o}), 3'b101);
    wait_idle();
    chk(fall_at - srx_at == 4, "R9 exit recovery", fall_at - srx_at, 4);
    chk(ref_req_o == 1'b0, "R9 owed cleared by exit", int'(ref_req_o), 0);
    chk(cke_o && !cs_no && ras_no && cas_no && we_no, "R1 NOP after exit", int'(cke_o), 1);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_burst();
    t_urgent();
    t_saturate();
    t_selfref();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule